// File: doc/BRIEF.md
# Programmable Chip-Select and Data Pin Decoder

This block drives a single general-purpose pin from activity on a host I/O bus. A programmable 11-bit base address is compared against the host address. A window field sets how many low address bits are left out of the comparison, so a hit covers 1, 2, 4 or 8 consecutive byte addresses. A bus cycle counts as a hit only while the address-enable line is low, which marks a non-DMA cycle.

A pin-mode field gives the pin one of four roles. In the off role the pin is tri-stated. In the chip-select role it shows a select that is gated by the read strobe, the write strobe or either one, with selectable polarity. In the output role it holds a bit that host writes load from data bit 0. In the input role a host read returns the pin level on data bit 0. An inversion option applies to both data roles. All configuration fields are plain inputs, driven by a register block elsewhere. Every output is registered.

Top module: `gpio_sel_decoder`

## Requirements
- R1: While `rst` is high, and after it is released with `cfg_mode` = 00, `pin_oe`, `pin_out` and `bus_d0_oe` are 0. The stored output bit resets to 0, so selecting the output role afterwards without any write drives `pin_out` = 0 with `pin_oe` = 1.
- R2: The address comparison uses `cfg_win`. Value 00 compares bits 10..0, 01 compares bits 10..1, 10 compares bits 10..2 and 11 compares bits 10..3. Address bits below the compared range have no effect on a hit.
- R3: A select is asserted only when `bus_aen` is low, the address matches, and a qualifying strobe is low. A high `bus_aen` or an address miss always leaves the select inactive.
- R4: `cfg_cs_qual` bit 0 lets the read strobe `bus_rd_n` qualify the select, and bit 1 lets the write strobe `bus_wr_n` qualify it. Value 11 accepts either strobe and 00 never selects.
- R5: In the chip-select role (`cfg_mode` = 01), `pin_oe` = 1. With `cfg_cs_pol` = 0 the pin is low while selected and high otherwise. With `cfg_cs_pol` = 1 it is high while selected and low otherwise.
- R6: In the output role (`cfg_mode` = 10), `pin_oe` = 1. A write hit loads `bus_d0_in` XOR `cfg_inv` into the stored bit, and that bit is driven on `pin_out`. Write misses, reads and idle cycles leave the stored bit unchanged, and `bus_d0_oe` stays 0.
- R7: In the input role (`cfg_mode` = 11), `pin_oe` = 0. A read hit drives `bus_d0_oe` = 1 and `bus_d0_out` = `pin_in` XOR `cfg_inv` for that cycle. Otherwise `bus_d0_oe` = 0, and a write hit has no effect on it.
- R8: In the off role (`cfg_mode` = 00), `pin_oe` and `pin_out` are 0 and `bus_d0_oe` is 0 whatever the bus does.
- R9: Every output reflects the inputs sampled at the previous rising clock edge. Each result appears exactly one cycle after its stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 11 | Programmed base address |
| cfg_win | input | 2 | Decode window select (1/2/4/8 bytes) |
| cfg_mode | input | 2 | Pin role: 00 off, 01 chip select, 10 output, 11 input |
| cfg_cs_qual | input | 2 | Strobe qualification: bit0 read, bit1 write |
| cfg_cs_pol | input | 1 | Select polarity, 1 = active high |
| cfg_inv | input | 1 | Invert data between pin and data bit 0 |
| bus_addr | input | 11 | Host address bits 10..0 |
| bus_aen | input | 1 | Address enable, hits only while low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_d0_in | input | 1 | Host data bit 0 during writes |
| pin_in | input | 1 | Level sensed on the pin |
| pin_out | output | 1 | Value driven on the pin |
| pin_oe | output | 1 | Pin output enable |
| bus_d0_out | output | 1 | Data bit 0 returned on reads |
| bus_d0_oe | output | 1 | Enable for bus_d0_out |

## Verification
Every result is due one clock after the bus and configuration inputs that cause it: the pin level, the pin enable and the returned data bit each pass through one output register, and a write updates the stored bit on that same edge. The bench applies each stimulus between edges, waits for one rising edge, and samples shortly after it. The hold checks for the stored bit are made on the following cycles, under stimulus that must not change it. Cycles are never counted from the release of reset, so a result is never read at a moment when another register in the path is still filling.

// File: rtl/gpio_sel_pkg.sv
package gpio_sel_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_CS   = 2'b01,
    PM_DOUT = 2'b10,
    PM_DIN  = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_addr_match.sv
module gpio_addr_match #(
  parameter int ADDR_W = 11,
  parameter int WIN_W  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIN_W-1:0]  win,
  output logic              hit
);
  logic [ADDR_W-1:0] bit_ok;

  // Bit i takes part in the compare only when it lies at or above the window size.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_ok[i] = (int'(win) > i) || (addr[i] == base[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/gpio_cs_gen.sv
module gpio_cs_gen (
  input  logic       match,
  input  logic       aen,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] qual,
  input  logic       pol,
  output logic       rd_hit,
  output logic       wr_hit,
  output logic       sel,
  output logic       level
);
  always_comb begin
    rd_hit = match && !aen && !rd_n;
    wr_hit = match && !aen && !wr_n;
    sel    = (qual[0] && rd_hit) || (qual[1] && wr_hit);
    level  = pol ? sel : !sel;
  end
endmodule

// File: rtl/gpio_data_path.sv
module gpio_data_path (
  input  logic clk,
  input  logic rst,
  input  logic dout_en,
  input  logic din_en,
  input  logic wr_hit,
  input  logic rd_hit,
  input  logic inv,
  input  logic d0_in,
  input  logic pin_in,
  output logic pin_next,
  output logic d0_drive,
  output logic d0_next
);
  logic store_q;
  logic load;

  assign load     = dout_en && wr_hit;
  assign pin_next = load ? (d0_in ^ inv) : store_q;
  assign d0_drive = din_en && rd_hit;
  assign d0_next  = pin_in ^ inv;

  always_ff @(posedge clk) begin
    if (rst) store_q <= 1'b0;
    else if (load) store_q <= d0_in ^ inv;
  end

  // R6: the stored bit moves only on an output-role write hit
  p_store_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(store_q));
endmodule

// File: rtl/gpio_sel_decoder.sv
module gpio_sel_decoder #(
  parameter int ADDR_W = 11,
  parameter int WIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [WIN_W-1:0]  cfg_win,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_cs_qual,
  input  logic              cfg_cs_pol,
  input  logic              cfg_inv,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_aen,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic              bus_d0_in,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              bus_d0_out,
  output logic              bus_d0_oe
);
  import gpio_sel_pkg::*;

  localparam int MAX_IGN = (1 << WIN_W) - 1;

  pin_mode_e mode;
  logic match, rd_hit, wr_hit, sel, cs_level;
  logic pin_next, d0_drive, d0_next;
  logic pin_out_q, pin_oe_q, d0_out_q, d0_oe_q;

  assign mode = pin_mode_e'(cfg_mode);

  gpio_addr_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_match (
    .base(cfg_base), .addr(bus_addr), .win(cfg_win), .hit(match)
  );

  gpio_cs_gen u_cs (
    .match(match), .aen(bus_aen), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .qual(cfg_cs_qual), .pol(cfg_cs_pol),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .sel(sel), .level(cs_level)
  );

  gpio_data_path u_data (
    .clk(clk), .rst(rst),
    .dout_en(mode == PM_DOUT), .din_en(mode == PM_DIN),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .inv(cfg_inv),
    .d0_in(bus_d0_in), .pin_in(pin_in),
    .pin_next(pin_next), .d0_drive(d0_drive), .d0_next(d0_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out_q <= 1'b0;
      pin_oe_q  <= 1'b0;
      d0_out_q  <= 1'b0;
      d0_oe_q   <= 1'b0;
    end else begin
      unique case (mode)
        PM_CS: begin
          pin_out_q <= cs_level;
          pin_oe_q  <= 1'b1;
        end
        PM_DOUT: begin
          pin_out_q <= pin_next;
          pin_oe_q  <= 1'b1;
        end
        default: begin
          pin_out_q <= 1'b0;
          pin_oe_q  <= 1'b0;
        end
      endcase
      d0_oe_q  <= d0_drive;
      d0_out_q <= d0_drive ? d0_next : 1'b0;
    end
  end

  assign pin_out    = pin_out_q;
  assign pin_oe     = pin_oe_q;
  assign bus_d0_out = d0_out_q;
  assign bus_d0_oe  = d0_oe_q;

  // R2: a difference in an always-compared bit keeps the select idle
  p_win_miss_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_CS && bus_addr[ADDR_W-1:MAX_IGN] != cfg_base[ADDR_W-1:MAX_IGN])
    |=> (pin_out == !$past(cfg_cs_pol)));

  // R3: a high address enable keeps the select idle
  p_cs_aen_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_CS && bus_aen) |=> (pin_oe && pin_out == !$past(cfg_cs_pol)));

  // R4: no qualifying strobe bits means never selected
  p_cs_never_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_CS && cfg_cs_qual == 2'b00) |=> (pin_out == !$past(cfg_cs_pol)));

  // R5: a select forces the active level on the pin
  p_cs_level_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_CS && sel) |=> (pin_oe && pin_out == $past(cfg_cs_pol)));

  // R7: the data bit is driven only after an input-role read hit
  p_d0_only_din_r7: assert property (@(posedge clk) disable iff (rst)
    !(mode == PM_DIN && rd_hit) |=> !bus_d0_oe);

  // R8: the off role never drives the pin
  p_off_hiz_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == PM_OFF) |=> (!pin_oe && !pin_out));
endmodule

// File: tb/gpio_sel_decoder_tb.sv
module gpio_sel_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [10:0] cfg_base;
  logic [1:0]  cfg_win, cfg_mode, cfg_cs_qual;
  logic        cfg_cs_pol, cfg_inv;
  logic [10:0] bus_addr;
  logic        bus_aen, bus_rd_n, bus_wr_n, bus_d0_in, pin_in;
  logic        pin_out, pin_oe, bus_d0_out, bus_d0_oe;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gpio_sel_decoder dut_i (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_win(cfg_win),
    .cfg_mode(cfg_mode), .cfg_cs_qual(cfg_cs_qual), .cfg_cs_pol(cfg_cs_pol),
    .cfg_inv(cfg_inv), .bus_addr(bus_addr), .bus_aen(bus_aen),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_d0_in(bus_d0_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .bus_d0_out(bus_d0_out), .bus_d0_oe(bus_d0_oe)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One rising edge, then sample 1 ns later (R9: results due one cycle after stimulus)
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_bus();
    bus_aen = 1'b0; bus_rd_n = 1'b1; bus_wr_n = 1'b1; bus_d0_in = 1'b0;
    bus_addr = cfg_base;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    cfg_base = 11'h5A8; cfg_win = 2'b00; cfg_mode = 2'b00; cfg_cs_qual = 2'b11;
    cfg_cs_pol = 1'b0; cfg_inv = 1'b0; pin_in = 1'b0;
    idle_bus();
    step(); step();
    chk("R1 reset outputs", {1'b0, pin_oe, pin_out, bus_d0_oe}, 4'b0000);
    rst = 1'b0;
    step();
    chk("R1 after release", {1'b0, pin_oe, pin_out, bus_d0_oe}, 4'b0000);
    // stored bit after reset, observed in the output role with no write
    cfg_mode = 2'b10;
    step();
    chk("R1 stored bit zero", {2'b00, pin_oe, pin_out}, 4'b0010);

    // R2: window sweep, chip select active high, qualified by either strobe
    cfg_mode = 2'b01; cfg_cs_pol = 1'b1; cfg_cs_qual = 2'b11;
    for (int w = 0; w < 4; w++) begin
      for (int off = 0; off < 16; off++) begin
        cfg_win = w[1:0];
        bus_addr = cfg_base ^ 11'(off);
        bus_aen = 1'b0; bus_rd_n = 1'b0; bus_wr_n = 1'b1;
        step();
        chk("R2 window", {2'b00, pin_oe, pin_out}, {2'b00, 1'b1, ((off >> w) == 0)});
      end
    end

    // R3/R4/R5: strobe, enable, qualifier and polarity sweep
    cfg_win = 2'b00;
    for (int v = 0; v < 128; v++) begin
      logic q0, q1, pol, aen, rd, wr, m, sel, expv;
      {q1, q0, pol, aen, rd, wr, m} = v[6:0];
      cfg_cs_qual = {q1, q0}; cfg_cs_pol = pol;
      bus_aen = aen; bus_rd_n = rd; bus_wr_n = wr;
      bus_addr = m ? cfg_base : (cfg_base ^ 11'h400);
      step();
      sel  = !aen && m && ((q0 && !rd) || (q1 && !wr));
      expv = pol ? sel : !sel;
      chk("R3 R4 R5 select", {2'b00, pin_oe, pin_out}, {2'b00, 1'b1, expv});
    end

    // R6: output role
    cfg_mode = 2'b10;
    for (int v = 0; v < 4; v++) begin
      logic inv, d;
      {inv, d} = v[1:0];
      cfg_inv = inv;
      idle_bus(); bus_wr_n = 1'b0; bus_d0_in = d;
      step();
      chk("R6 write hit", {1'b0, pin_oe, pin_out, bus_d0_oe}, {1'b0, 1'b1, d ^ inv, 1'b0});
      idle_bus(); bus_wr_n = 1'b0; bus_d0_in = !d; bus_addr = cfg_base ^ 11'h010;
      step();
      chk("R6 write miss holds", {2'b00, pin_oe, pin_out}, {2'b00, 1'b1, d ^ inv});
      idle_bus(); bus_wr_n = 1'b0; bus_d0_in = !d; bus_aen = 1'b1;
      step();
      chk("R6 aen write holds", {2'b00, pin_oe, pin_out}, {2'b00, 1'b1, d ^ inv});
      idle_bus(); bus_rd_n = 1'b0;
      step();
      chk("R6 read holds", {1'b0, pin_oe, pin_out, bus_d0_oe}, {1'b0, 1'b1, d ^ inv, 1'b0});
    end

    // R7: input role
    cfg_mode = 2'b11;
    for (int v = 0; v < 4; v++) begin
      logic inv, p;
      {inv, p} = v[1:0];
      cfg_inv = inv; pin_in = p;
      idle_bus(); bus_rd_n = 1'b0;
      step();
      chk("R7 read hit", {1'b0, pin_oe, bus_d0_oe, bus_d0_out}, {1'b0, 1'b0, 1'b1, p ^ inv});
      idle_bus();
      step();
      chk("R7 idle releases", {2'b00, pin_oe, bus_d0_oe}, 4'b0000);
      idle_bus(); bus_wr_n = 1'b0; bus_d0_in = 1'b1;
      step();
      chk("R7 write no effect", {2'b00, pin_oe, bus_d0_oe}, 4'b0000);
      idle_bus(); bus_rd_n = 1'b0; bus_addr = cfg_base ^ 11'h001;
      step();
      chk("R7 read miss", {2'b00, pin_oe, bus_d0_oe}, 4'b0000);
    end

    // R8: off role under bus activity
    cfg_mode = 2'b00;
    for (int v = 0; v < 4; v++) begin
      idle_bus(); bus_rd_n = v[0]; bus_wr_n = v[1];
      step();
      chk("R8 off role", {1'b0, pin_oe, pin_out, bus_d0_oe}, 4'b0000);
    end

    finish_run();
  end
endmodule